// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This engine follows a chain of transmit descriptors held in memory. When it receives a start command with the address of the first descriptor, it reads that descriptor's header: a configuration word, a packet-size word and a fragment count. It then reads each fragment entry in turn, which is an address low half, an address high half and a byte size. For each fragment it hands a fetch request to a downstream packet assembler and waits until the assembler reports that the fragment is done.

After the last fragment it writes a completion status into the first word of the descriptor. It then reads the link word that follows the fragment entries and moves on to the next descriptor. The walk stops when a link word carries the end-of-list mark, or when the halt input is raised.

The engine has one word-wide memory port that uses a request/acknowledge handshake. Descriptors can be packed as 16-bit words, or as 32-bit slots whose low half carries the data. In the 32-bit layout every word offset is doubled. The fragment lengths granted within one packet never add up to more than the transmit buffer size.

Top module: `txd_walker`

## Requirements
- R1: A `start` pulse while idle latches `start_base` as the descriptor address and raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored and does not change the walk.
- R2: The header words are read at word offsets 1 (configuration), 2 (packet size) and 3 (fragment count) from the descriptor base. The byte address of word offset k is base + 2·k when `wide_mode` is 0 and base + 4·k when it is 1. Read data is taken from `mem_rdata[15:0]`.
- R3: Fragment i (counting from 0) is described by the words at offsets 4+3i (address bits 15:0), 5+3i (address bits 31:16) and 6+3i (size in bytes). For each fragment, `frag_valid` is raised with `frag_addr` = {high, low}. It stays high, with address and length stable, until `frag_done`. No memory access takes place while it is high.
- R4: Within one packet, the granted `frag_len` is the smaller of the fragment size and BUF_BYTES minus the lengths already granted in that packet. The granted lengths of a packet therefore never add up to more than BUF_BYTES.
- R5: A fragment count of 0 produces no fragment request. The status write and the link read still take place.
- R6: Each configuration word read sets `tx_ctl` to its bits 15:12 and sets `pint_flag` to its bit 13. A later configuration word with bit 13 at 0 clears `pint_flag`.
- R7: After the fragments of a descriptor, the value 16'h0001 (bit 0 = packet transmitted, bits 11:0 of the loaded control otherwise zero) is written to word offset 0 of the descriptor. `pkt_done` pulses for one cycle right after that write is acknowledged.
- R8: Unless halted, the link word is read at offset 4+3·count. The next descriptor base is {base[AW-1:16], link[15:1], 0}. Link bit 0 = 1 ends the walk.
- R9: If `halt_tx` is high when the status write is acknowledged, the walk ends without reading the link word.
- R10: When the walk ends, `walk_done` is high for exactly one cycle and `busy` is low in the following cycle.
- R11: `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`, and `mem_req` and `frag_valid` are never high together.
- R12: During reset, `busy`, `mem_req`, `frag_valid`, `pkt_done` and `walk_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a walk at `start_base` |
| start_base | input | AW | Address of the first descriptor |
| wide_mode | input | 1 | 1: 32-bit descriptor slots (word offsets doubled) |
| halt_tx | input | 1 | Stop after the current packet's status write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: the access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 16 | Read data |
| frag_valid | output | 1 | Fragment fetch request |
| frag_addr | output | AW | Fragment byte address |
| frag_len | output | 16 | Granted fragment length in bytes |
| frag_done | input | 1 | Assembler finished the fragment |
| busy | output | 1 | Walk in progress (transmit pending) |
| tx_ctl | output | 4 | Control bits 15:12 of the last configuration word |
| pint_flag | output | 1 | Programmable-interrupt status of the last packet |
| pkt_done | output | 1 | One-cycle pulse after each status write |
| walk_done | output | 1 | One-cycle pulse when the walk ends |

## Verification
The checker watches the two handshakes on every cycle:
- request, address and direction stay stable until acknowledged;
- fragment address and length stay stable until done;
- memory traffic and fragment requests never overlap;
- no granted length exceeds the buffer.

It also checks that `busy` rises after a start from idle and falls after `walk_done`.

Only the bench scenarios can show the parts that depend on the descriptor contents:
- the address arithmetic for the header, fragment and link words in both layouts;
- the per-packet clamp;
- zero-count descriptors;
- halting, following the chain and the end-of-list mark;
- the status values written back.

The bench checks each of these against a model that walks the same memory image.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_PSZ, S_CNT, S_FLO, S_FHI, S_FSZ, S_FRAG, S_STAT, S_LINK, S_END
  } walk_st_t;

  localparam int          CTL_MSB     = 15;
  localparam int          CTL_LSB     = 12;
  localparam int          PINT_BIT    = 13;
  localparam int          HDR_WORDS   = 4;
  localparam int          FRAG_STRIDE = 3;
  localparam logic [15:0] STATUS_WORD = 16'h0001;
endpackage

// File: rtl/txw_addr_gen.sv
module txw_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 18
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] woff,
  input  logic          wide,
  output logic [AW-1:0] addr
);
  logic [OW+1:0] boff;

  // word offset to byte offset: x2 for 16-bit slots, x4 for 32-bit slots
  assign boff = wide ? {woff, 2'b00} : {1'b0, woff, 1'b0};
  assign addr = base + AW'(boff);
endmodule

// File: rtl/txw_clamp.sv
module txw_clamp #(
  parameter int BUF_BYTES = 1536,
  parameter int TW        = 11
) (
  input  logic [TW-1:0] used,
  input  logic [15:0]   want,
  output logic [15:0]   grant,
  output logic [TW-1:0] used_next
);
  logic [TW-1:0] room;

  assign room = TW'(BUF_BYTES) - used;

  always_comb begin
    if (17'(want) > 17'(room)) grant = 16'(room);
    else                       grant = want;
  end

  assign used_next = used + TW'(grant);
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic          wide_mode,
  input  logic          halt_tx,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          frag_valid,
  output logic [AW-1:0] frag_addr,
  output logic [15:0]   frag_len,
  input  logic          frag_done,
  output logic          busy,
  output logic [3:0]    tx_ctl,
  output logic          pint_flag,
  output logic          pkt_done,
  output logic          walk_done
);
  localparam int CW = 16;
  localparam int OW = CW + 2;
  localparam int TW = $clog2(BUF_BYTES + 1);

  walk_st_t      st, st_d;
  logic [AW-1:0] base_q, base_d;
  logic [3:0]    cfg_q, cfg_d;
  logic          pint_q, pint_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [15:0]   flo_q, flo_d;
  logic [15:0]   fhi_q, fhi_d;
  logic [15:0]   fsz_q, fsz_d;
  logic [TW-1:0] tot_q, tot_d;
  logic          pkt_q, pkt_d;

  logic [OW-1:0] frag_off, link_off, woff;
  logic [TW-1:0] tot_nxt;
  logic          last_frag;

  // word offsets of the current fragment entry and of the link word
  assign frag_off  = OW'(idx_q) * OW'(FRAG_STRIDE) + OW'(HDR_WORDS);
  assign link_off  = OW'(cnt_q) * OW'(FRAG_STRIDE) + OW'(HDR_WORDS);
  assign last_frag = (17'(idx_q) + 17'd1) == 17'(cnt_q);

  always_comb begin
    unique case (st)
      S_CFG:   woff = OW'(1);
      S_PSZ:   woff = OW'(2);
      S_CNT:   woff = OW'(3);
      S_FLO:   woff = frag_off;
      S_FHI:   woff = frag_off + OW'(1);
      S_FSZ:   woff = frag_off + OW'(2);
      S_LINK:  woff = link_off;
      default: woff = '0;
    endcase
  end

  txw_addr_gen #(.AW(AW), .OW(OW)) u_addr (
    .base (base_q),
    .woff (woff),
    .wide (wide_mode),
    .addr (mem_addr)
  );

  txw_clamp #(.BUF_BYTES(BUF_BYTES), .TW(TW)) u_clamp (
    .used      (tot_q),
    .want      (fsz_q),
    .grant     (frag_len),
    .used_next (tot_nxt)
  );

  assign mem_req    = (st == S_CFG) || (st == S_PSZ) || (st == S_CNT) || (st == S_FLO) ||
                      (st == S_FHI) || (st == S_FSZ) || (st == S_STAT) || (st == S_LINK);
  assign mem_we     = (st == S_STAT);
  assign mem_wdata  = mem_we ? STATUS_WORD : 16'h0000;
  assign frag_valid = (st == S_FRAG);
  assign frag_addr  = AW'({fhi_q, flo_q});
  assign busy       = (st != S_IDLE);
  assign walk_done  = (st == S_END);
  assign tx_ctl     = cfg_q;
  assign pint_flag  = pint_q;
  assign pkt_done   = pkt_q;

  // next-state process
  always_comb begin
    st_d   = st;
    base_d = base_q;
    cfg_d  = cfg_q;
    pint_d = pint_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    flo_d  = flo_q;
    fhi_d  = fhi_q;
    fsz_d  = fsz_q;
    tot_d  = tot_q;
    pkt_d  = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        base_d = start_base;
        st_d   = S_CFG;
      end
      S_CFG: if (mem_ack) begin
        cfg_d  = mem_rdata[CTL_MSB:CTL_LSB];
        pint_d = mem_rdata[PINT_BIT];
        tot_d  = '0;
        st_d   = S_PSZ;
      end
      S_PSZ: if (mem_ack) st_d = S_CNT;
      S_CNT: if (mem_ack) begin
        cnt_d = mem_rdata;
        idx_d = '0;
        st_d  = (mem_rdata == 16'h0000) ? S_STAT : S_FLO;
      end
      S_FLO: if (mem_ack) begin
        flo_d = mem_rdata;
        st_d  = S_FHI;
      end
      S_FHI: if (mem_ack) begin
        fhi_d = mem_rdata;
        st_d  = S_FSZ;
      end
      S_FSZ: if (mem_ack) begin
        fsz_d = mem_rdata;
        st_d  = S_FRAG;
      end
      S_FRAG: if (frag_done) begin
        tot_d = tot_nxt;
        idx_d = idx_q + CW'(1);
        st_d  = last_frag ? S_STAT : S_FLO;
      end
      S_STAT: if (mem_ack) begin
        pkt_d = 1'b1;
        st_d  = halt_tx ? S_END : S_LINK;
      end
      S_LINK: if (mem_ack) begin
        base_d = {base_q[AW-1:16], mem_rdata[15:1], 1'b0};
        st_d   = mem_rdata[0] ? S_END : S_CFG;
      end
      S_END:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      cfg_q  <= '0;
      pint_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      flo_q  <= '0;
      fhi_q  <= '0;
      fsz_q  <= '0;
      tot_q  <= '0;
      pkt_q  <= 1'b0;
    end else begin
      st     <= st_d;
      base_q <= base_d;
      cfg_q  <= cfg_d;
      pint_q <= pint_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      flo_q  <= flo_d;
      fhi_q  <= fhi_d;
      fsz_q  <= fsz_d;
      tot_q  <= tot_d;
      pkt_q  <= pkt_d;
    end
  end
endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1536
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          frag_valid,
  input logic          frag_done,
  input logic [AW-1:0] frag_addr,
  input logic [15:0]   frag_len,
  input logic          busy,
  input logic          walk_done
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && frag_valid));

  // R3
  frag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_done) |=> (frag_valid && $stable(frag_addr) && $stable(frag_len)));

  // R4
  frag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (32'(frag_len) <= 32'(BUF_BYTES)));

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> (!busy && !walk_done));
endmodule

bind txd_walker txw_walker_chk #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .frag_valid (frag_valid),
  .frag_done  (frag_done),
  .frag_addr  (frag_addr),
  .frag_len   (frag_len),
  .busy       (busy),
  .walk_done  (walk_done)
);

// File: tb/sim_txd_walker.sv
module sim_txd_walker;
  localparam int BUF = 1536;

  logic        clk = 1'b0;
  logic        rst_n, start, wide_mode, halt_tx;
  logic [31:0] start_base;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        frag_valid, frag_done;
  logic [31:0] frag_addr;
  logic [15:0] frag_len;
  logic        busy, pint_flag, pkt_done, walk_done;
  logic [3:0]  tx_ctl;

  always #5 clk = ~clk;

  txd_walker #(.AW(32), .BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .wide_mode(wide_mode), .halt_tx(halt_tx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .frag_valid(frag_valid), .frag_addr(frag_addr), .frag_len(frag_len), .frag_done(frag_done),
    .busy(busy), .tx_ctl(tx_ctl), .pint_flag(pint_flag), .pkt_done(pkt_done), .walk_done(walk_done)
  );

  logic [15:0] mem [0:8191];
  int total = 0, bad = 0;
  bit finished = 0;

  int          got_n, viol, n_walk, n_pkt, mdly, fdly;
  logic [31:0] got_addr [0:255];
  logic [15:0] got_len  [0:255];
  bit          pend;
  logic [31:0] pend_addr;

  int          exp_n, exp_pk;
  logic [31:0] exp_addr [0:255];
  logic [15:0] exp_len  [0:255];
  int unsigned exp_desc [0:15];
  logic [15:0] exp_cfg;
  int unsigned ch_base  [0:7];

  task automatic chk(bit ok, string msg, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic int unsigned widx(int unsigned base, bit wide, int unsigned off);
    return ((base + off * (wide ? 4 : 2)) >> 1) & 8191;
  endfunction

  function automatic logic [15:0] rd(int unsigned base, bit wide, int unsigned off);
    return mem[widx(base, wide, off)];
  endfunction

  // memory responder with random latency
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; pend = 0; mdly = 0; mem_rdata = '0;
    end else begin
      if (mem_req && frag_valid) viol++;
      if (mem_ack) begin
        mem_ack = 1'b0; pend = 0;
      end else if (mem_req) begin
        if (pend && mem_addr != pend_addr) viol++;
        pend = 1; pend_addr = mem_addr;
        if (mdly > 0) mdly--;
        else begin
          if (mem_we) mem[mem_addr[13:1]] = mem_wdata;
          mem_rdata = mem[mem_addr[13:1]];
          mem_ack = 1'b1;
          mdly = $urandom_range(0, 2);
        end
      end
    end
  end

  // fragment assembler stand-in
  always @(negedge clk) begin
    if (!rst_n) begin
      frag_done = 1'b0; fdly = 0;
    end else if (frag_done) begin
      frag_done = 1'b0;
    end else if (frag_valid) begin
      if (fdly > 0) fdly--;
      else begin
        if (got_n < 256) begin
          got_addr[got_n] = frag_addr;
          got_len[got_n]  = frag_len;
        end
        got_n++;
        frag_done = 1'b1;
        fdly = $urandom_range(0, 3);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (walk_done) n_walk++;
      if (pkt_done)  n_pkt++;
    end
  end

  task automatic model(int unsigned base, bit wide, bit halt);
    logic [15:0] cfg, cnt, lo, hi, sz, link;
    int unsigned tot, len;
    exp_n = 0; exp_pk = 0;
    for (int g = 0; g < 16; g++) begin
      cfg = rd(base, wide, 1);
      cnt = rd(base, wide, 3);
      tot = 0;
      exp_cfg = cfg;
      exp_desc[exp_pk] = base;
      exp_pk++;
      for (int i = 0; i < int'(cnt); i++) begin
        lo = rd(base, wide, 4 + 3 * i);
        hi = rd(base, wide, 5 + 3 * i);
        sz = rd(base, wide, 6 + 3 * i);
        len = (int'(sz) > BUF - int'(tot)) ? BUF - tot : sz;
        exp_addr[exp_n] = {hi, lo};
        exp_len[exp_n]  = 16'(len);
        exp_n++;
        tot += len;
      end
      if (halt) break;
      link = rd(base, wide, 4 + 3 * cnt);
      base = {base[31:16], link[15:1], 1'b0};
      if (link[0]) break;
    end
  endtask

  task automatic make_chain(int n, bit wide, int cfix, int sfix);
    int first, cnt;
    int unsigned b;
    logic [15:0] link;
    first = $urandom_range(1, 31 - n);
    for (int i = 0; i < n; i++) begin
      b = 32'h200 * (first + i);
      ch_base[i] = b;
      cnt = (cfix >= 0) ? cfix : $urandom_range(0, 4);
      mem[widx(b, wide, 0)] = 16'hDEAD;
      mem[widx(b, wide, 1)] = 16'($urandom);
      mem[widx(b, wide, 2)] = 16'($urandom);
      mem[widx(b, wide, 3)] = 16'(cnt);
      for (int j = 0; j < cnt; j++) begin
        mem[widx(b, wide, 4 + 3 * j)] = 16'($urandom);
        mem[widx(b, wide, 5 + 3 * j)] = 16'($urandom);
        mem[widx(b, wide, 6 + 3 * j)] = (sfix >= 0) ? 16'(sfix) : 16'($urandom_range(0, 700));
      end
      if (i == n - 1) link = (16'($urandom) & 16'hFFFE) | 16'h0001;
      else            link = 16'(32'h200 * (first + i + 1));
      mem[widx(b, wide, 4 + 3 * cnt)] = link;
    end
  endtask

  task automatic run_walk(int unsigned base, bit wide, bit halt, bit poke, string tag);
    model(base, wide, halt);
    n_walk = 0; n_pkt = 0; got_n = 0; viol = 0;
    @(negedge clk);
    wide_mode = wide; halt_tx = halt; start_base = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, $sformatf("R1 %s busy after start", tag), busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_base = 32'h0000_3E00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 20000 && !(n_walk > 0 && !busy); t++) @(negedge clk);
    chk(n_walk == 1, $sformatf("R10 %s walk_done pulses", tag), n_walk, 1);
    chk(got_n == exp_n, $sformatf("R3 R5 %s fragment request count", tag), got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], $sformatf("R3 %s frag %0d addr", tag, i), got_addr[i], exp_addr[i]);
      chk(got_len[i] == exp_len[i], $sformatf("R4 %s frag %0d len", tag, i), got_len[i], exp_len[i]);
    end
    chk(n_pkt == exp_pk, $sformatf("R7 R8 %s packets done", tag), n_pkt, exp_pk);
    for (int k = 0; k < exp_pk; k++)
      chk(rd(exp_desc[k], wide, 0) == 16'h0001, $sformatf("R7 %s status word %0d", tag, k),
          rd(exp_desc[k], wide, 0), 16'h0001);
    chk(tx_ctl == exp_cfg[15:12], $sformatf("R6 %s tx_ctl", tag), tx_ctl, exp_cfg[15:12]);
    chk(pint_flag == exp_cfg[13], $sformatf("R6 %s pint_flag", tag), pint_flag, exp_cfg[13]);
    chk(viol == 0, $sformatf("R11 %s handshake violations", tag), viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8192; i++) mem[i] = 16'h0000;
    rst_n = 1'b0; start = 1'b0; wide_mode = 1'b0; halt_tx = 1'b0; start_base = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_req == 0 && frag_valid == 0, "R12 outputs idle in reset",
        {busy, mem_req, frag_valid}, 0);
    chk(walk_done == 0 && pkt_done == 0, "R12 pulses low in reset", {walk_done, pkt_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    make_chain(1, 0, 2, -1);     run_walk(ch_base[0], 0, 0, 0, "R2 narrow single");
    make_chain(3, 1, -1, -1);    run_walk(ch_base[0], 1, 0, 0, "R2 wide chain");
    make_chain(1, 0, 0, -1);     run_walk(ch_base[0], 0, 0, 0, "R5 zero count");
    make_chain(2, 1, 0, -1);     run_walk(ch_base[0], 1, 0, 0, "R5 wide zero count chain");
    make_chain(1, 0, 3, 1000);   run_walk(ch_base[0], 0, 0, 0, "R4 clamp");
    chk(exp_len[1] == 16'd536 && exp_len[2] == 16'd0, "R4 clamp model values",
        {exp_len[1], exp_len[2]}, {16'd536, 16'd0});
    make_chain(2, 0, 2, -1);     run_walk(ch_base[0], 0, 1, 0, "R9 halt");
    chk(rd(ch_base[1], 0, 0) == 16'hDEAD, "R9 second descriptor untouched", rd(ch_base[1], 0, 0), 16'hDEAD);
    make_chain(2, 0, 1, -1);     run_walk(ch_base[0], 0, 0, 1, "R1 start while busy");
    make_chain(1, 0, 1, -1);
    mem[widx(ch_base[0], 0, 1)] = 16'hE123;
    run_walk(ch_base[0], 0, 0, 0, "R6 pint set");
    mem[widx(ch_base[0], 0, 0)] = 16'hDEAD;
    mem[widx(ch_base[0], 0, 1)] = 16'h5FFF;
    run_walk(ch_base[0], 0, 0, 0, "R6 pint cleared");

    for (int r = 0; r < 14; r++) begin
      bit w, h;
      w = 1'($urandom_range(0, 1));
      h = ($urandom_range(0, 5) == 0);
      make_chain($urandom_range(1, 4), w, -1, -1);
      run_walk(ch_base[0], w, h, 0, $sformatf("R8 random %0d", r));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule